// File: doc/BRIEF.md
# HDLC Controller Status and Interrupt Register

This block keeps the status word of an HDLC serial controller. It also holds the logic that sets and clears each status bit. Its inputs are strobes and levels from the transmitter, the receiver, the two FIFOs' occupancy counters and the active-low clear-to-send pin. The framing, CRC and FIFO storage sit elsewhere. The block reduces those inputs to a set of status bits. Some bits are sticky events that software clears by writing ones. Others are live levels that follow the hardware.

Two registers sit behind a one-bit address. Address 0 is the status word, where a write clears the sticky bits whose positions carry a 1. Address 1 is the interrupt-enable word. The interrupt request is raised when any interrupt-capable status bit is set and its enable bit is set too. The transfer-mode input selects single-word or four-word bursts, and it changes both the FIFO-available rules and the range of the remaining-bytes field. Each of the two DMA-enable inputs holds its own FIFO-available bit at zero.

Top module: `hdlc_stat_reg`

## Requirements
- R1: While reset is asserted and right after it, the status word, the enable word and `irq` all read 0.
- R2: On an `rx_frame_done` strobe, bits [3:0] capture the valid byte count on `rx_end_bytes` minus one, with a count of 0 treated as 1. In single-word mode (`quad_mode`=0) only the low two bits are kept and bits [3:2] are 0. The field holds its value until the next strobe.
- R3: Bit 5 sets when `tx_close_sent` or `tx_abort_sent` is high while `tx_free` equals the transmit FIFO depth. Writing 1 to bit 5 at address 0 clears it.
- R4: Bit 6 is 1 when `tx_free` is at least 1 in single-word mode, or at least 4 in four-word mode. It is 0 whenever `tx_dma_en` is high. The bit follows its inputs one cycle later.
- R5: Bit 7 is the inverse of `cts_n` after a two-flop synchronizer. It is 1 while the pin is low, and it appears three clock edges after the pin changes.
- R6: Bit 8 sets on every rising or falling edge of the synchronized `cts_n`. It stays set until a 1 is written to bit 8 at address 0.
- R7: Bit 9 sets on a `tx_underrun` strobe and clears when a 1 is written to bit 9 at address 0.
- R8: Bit 10 is 1 when `rx_fill` is nonzero in single-word mode. In four-word mode it is 1 when `rx_fill` is at least 4, or when `rx_fill` is nonzero and `rx_last_mark` is high. It is 0 whenever `rx_dma_en` is high, and it follows its inputs one cycle later.
- R9: If a set condition and a write-one-to-clear reach the same sticky bit in one cycle, the bit ends up set.
- R10: `irq` is high exactly when a status bit among 5, 6, 8, 9 and 10 is 1 and the enable word has a 1 at that same position. Bit 7 never raises `irq`.
- R11: Bits 4 and 31..11 of the status word always read 0. A status write has no effect on bits [3:0], 6, 7 or 10, and writing 0 to a sticky bit leaves it unchanged. The enable word keeps only bits 5, 6, 8, 9 and 10 and reads 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 = status word, 1 = interrupt-enable word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data of the addressed word |
| irq | output | 1 | Interrupt request |
| quad_mode | input | 1 | 0 = single-word transfers, 1 = four-word transfers |
| tx_dma_en | input | 1 | Transmit DMA active |
| rx_dma_en | input | 1 | Receive DMA active |
| tx_free | input | 4 | Free entries in the transmit FIFO |
| rx_fill | input | 4 | Filled entries in the receive FIFO |
| rx_last_mark | input | 1 | The receive FIFO holds a frame's last word |
| rx_frame_done | input | 1 | Strobe: a received frame is complete |
| rx_end_bytes | input | 5 | Valid bytes in the final boundary (1..16) |
| tx_close_sent | input | 1 | Strobe: closing flag sent |
| tx_abort_sent | input | 1 | Strobe: abort sequence sent |
| tx_underrun | input | 1 | Strobe: transmitter ran out of data mid-frame |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |

## Verification
The hardest case to reach from the ports is a cycle in which a sticky event and a software clear of the same bit arrive together. The case gets harder when the event is a CTS edge, because that edge surfaces only after three clock edges of synchronization. The stimulus aims underrun and frame-complete strobes at exactly the cycle of a status write. A long random phase also toggles `cts_n` and issues clears often, so that edge detections land on write cycles. The four-word receive rule is covered by a sweep of `rx_fill` with the last-word marker both off and on. A cycle-by-cycle bench model checks every readable bit throughout the run.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;

    localparam int STAT_W   = 32;
    localparam int GROUP    = 4;   // entries per burst in four-word mode
    localparam int WORD_B   = 4;   // bytes per FIFO word
    localparam int REM_W    = $clog2(GROUP * WORD_B);
    localparam int BYTES_W  = $clog2(GROUP * WORD_B + 1);

    localparam int B_TXDONE = 5;
    localparam int B_TXAV   = 6;
    localparam int B_CTSLV  = 7;
    localparam int B_CTSCHG = 8;
    localparam int B_TXUR   = 9;
    localparam int B_RXAV   = 10;

    localparam logic [STAT_W-1:0] IRQ_MASK =
        (STAT_W'(1) << B_TXDONE) | (STAT_W'(1) << B_TXAV) |
        (STAT_W'(1) << B_CTSCHG) | (STAT_W'(1) << B_TXUR) |
        (STAT_W'(1) << B_RXAV);

    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_QUAD   = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [REM_W-1:0]  rem;
        logic              tx_done;
        logic              tx_av;
        logic              cts_lvl;
        logic              cts_chg;
        logic              tx_ur;
        logic              rx_av;
        logic [STAT_W-1:0] ien;
    } stat_state_t;

endpackage

// File: rtl/hsr_cts_sync.sv
module hsr_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n,
    output logic edge_seen
);

    logic [STAGES:0] chain_d;
    logic [STAGES:0] chain_q;

    always_comb begin
        chain_d[0] = pin_n;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b1;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign sync_n    = chain_q[STAGES-1];
    assign edge_seen = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/hsr_fifo_qual.sv
module hsr_fifo_qual #(
    parameter int DEPTH = 8,
    parameter int GROUP = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] level,
    input  logic          quad,
    input  logic          dma_en,
    input  logic          last_mark,
    output logic          avail
);

    logic any_entry;
    logic full_group;
    logic ready;

    assign any_entry  = (level != '0);
    assign full_group = (level >= CW'(GROUP));

    always_comb begin
        if (quad) ready = full_group | (any_entry & last_mark);
        else      ready = any_entry;
        avail = ready & ~dma_en;
    end

endmodule

// File: rtl/hsr_rem_calc.sv
module hsr_rem_calc
    import hdlc_stat_pkg::*;
(
    input  logic [BYTES_W-1:0] bytes,
    input  logic               quad,
    output logic [REM_W-1:0]   rem
);

    logic [BYTES_W-1:0] less_one;

    always_comb begin
        less_one = (bytes == '0) ? '0 : bytes - BYTES_W'(1);
        if (quad) rem = less_one[REM_W-1:0];
        else      rem = {{(REM_W-2){1'b0}}, less_one[1:0]};
    end

endmodule

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg
    import hdlc_stat_pkg::*;
#(
    parameter int TX_DEPTH   = 8,
    parameter int RX_DEPTH   = 8,
    parameter int CTS_STAGES = 2,
    parameter int TX_CW      = $clog2(TX_DEPTH + 1),
    parameter int RX_CW      = $clog2(RX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic               cpu_addr,
    input  logic [STAT_W-1:0]  cpu_wdata,
    output logic [STAT_W-1:0]  cpu_rdata,
    output logic               irq,
    input  logic               quad_mode,
    input  logic               tx_dma_en,
    input  logic               rx_dma_en,
    input  logic [TX_CW-1:0]   tx_free,
    input  logic [RX_CW-1:0]   rx_fill,
    input  logic               rx_last_mark,
    input  logic               rx_frame_done,
    input  logic [BYTES_W-1:0] rx_end_bytes,
    input  logic               tx_close_sent,
    input  logic               tx_abort_sent,
    input  logic               tx_underrun,
    input  logic               cts_n
);

    stat_state_t        st_d;
    stat_state_t        st_q;
    logic               cts_sync_n;
    logic               cts_edge;
    logic               tx_av_w;
    logic               rx_av_w;
    logic [REM_W-1:0]   rem_w;
    logic               tx_empty;
    logic [STAT_W-1:0]  clr_bits;
    logic [STAT_W-1:0]  stat_word;
    logic [STAT_W-1:0]  ien_word;
    reg_sel_e           sel;

    hsr_cts_sync #(.STAGES(CTS_STAGES)) cts_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (cts_n),
        .sync_n    (cts_sync_n),
        .edge_seen (cts_edge)
    );

    hsr_fifo_qual #(.DEPTH(TX_DEPTH), .GROUP(GROUP), .CW(TX_CW)) txq_i (
        .level     (tx_free),
        .quad      (quad_mode),
        .dma_en    (tx_dma_en),
        .last_mark (1'b0),
        .avail     (tx_av_w)
    );

    hsr_fifo_qual #(.DEPTH(RX_DEPTH), .GROUP(GROUP), .CW(RX_CW)) rxq_i (
        .level     (rx_fill),
        .quad      (quad_mode),
        .dma_en    (rx_dma_en),
        .last_mark (rx_last_mark),
        .avail     (rx_av_w)
    );

    hsr_rem_calc rem_i (
        .bytes (rx_end_bytes),
        .quad  (quad_mode),
        .rem   (rem_w)
    );

    assign sel      = reg_sel_e'(cpu_addr);
    assign tx_empty = (tx_free == TX_CW'(TX_DEPTH));
    assign clr_bits = (cpu_wr && sel == SEL_STATUS) ? (cpu_wdata & IRQ_MASK) : '0;

    // next-state: set events take priority over a same-cycle clear
    always_comb begin
        st_d = st_q;

        st_d.tx_done = (st_q.tx_done & ~clr_bits[B_TXDONE])
                     | ((tx_close_sent | tx_abort_sent) & tx_empty);
        st_d.cts_chg = (st_q.cts_chg & ~clr_bits[B_CTSCHG]) | cts_edge;
        st_d.tx_ur   = (st_q.tx_ur & ~clr_bits[B_TXUR]) | tx_underrun;

        st_d.tx_av   = tx_av_w;
        st_d.rx_av   = rx_av_w;
        st_d.cts_lvl = ~cts_sync_n;

        if (rx_frame_done) st_d.rem = rem_w;

        if (cpu_wr && sel == SEL_ENABLE) st_d.ien = cpu_wdata & IRQ_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_word                 = '0;
        stat_word[REM_W-1:0]      = st_q.rem;
        stat_word[B_TXDONE]       = st_q.tx_done;
        stat_word[B_TXAV]         = st_q.tx_av;
        stat_word[B_CTSLV]        = st_q.cts_lvl;
        stat_word[B_CTSCHG]       = st_q.cts_chg;
        stat_word[B_TXUR]         = st_q.tx_ur;
        stat_word[B_RXAV]         = st_q.rx_av;
        ien_word                  = st_q.ien;
    end

    assign cpu_rdata = (sel == SEL_ENABLE) ? ien_word : stat_word;
    assign irq       = |(stat_word & ien_word & IRQ_MASK);

endmodule

// File: rtl/hdlc_stat_reg_chk.sv
module hdlc_stat_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_wr,
    input logic        cpu_addr,
    input logic        clr_done,
    input logic        clr_chg,
    input logic        clr_ur,
    input logic        quad_mode,
    input logic        tx_dma_en,
    input logic        rx_dma_en,
    input logic        rx_frame_done,
    input logic        tx_close_sent,
    input logic        tx_abort_sent,
    input logic        tx_underrun,
    input logic [31:0] stat,
    input logic [31:0] ien,
    input logic        irq
);

    logic stat_wr;
    assign stat_wr = cpu_wr && !cpu_addr;

    assert_rem_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done && !quad_mode) |=> (stat[3:2] == 2'b00));

    assert_done_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_done && !tx_close_sent && !tx_abort_sent) |=> !stat[5]);

    assert_txav_dma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_en |=> !stat[6]);

    assert_chg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[8] && !(stat_wr && clr_chg)) |=> stat[8]);

    assert_ur_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && clr_ur && !tx_underrun) |=> !stat[9]);

    assert_rxav_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_en |=> !stat[10]);

    assert_ur_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |=> stat[9]);

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat & ien) != 32'h0));

endmodule

bind hdlc_stat_reg hdlc_stat_reg_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr        (cpu_wr),
    .cpu_addr      (cpu_addr),
    .clr_done      (cpu_wdata[5]),
    .clr_chg       (cpu_wdata[8]),
    .clr_ur        (cpu_wdata[9]),
    .quad_mode     (quad_mode),
    .tx_dma_en     (tx_dma_en),
    .rx_dma_en     (rx_dma_en),
    .rx_frame_done (rx_frame_done),
    .tx_close_sent (tx_close_sent),
    .tx_abort_sent (tx_abort_sent),
    .tx_underrun   (tx_underrun),
    .stat          (stat_word),
    .ien           (ien_word),
    .irq           (irq)
);

// File: tb/hdlc_stat_reg_tb.sv
module hdlc_stat_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_addr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        irq;
    logic        quad_mode = 1'b0;
    logic        tx_dma_en = 1'b0;
    logic        rx_dma_en = 1'b0;
    logic [3:0]  tx_free = '0;
    logic [3:0]  rx_fill = '0;
    logic        rx_last_mark = 1'b0;
    logic        rx_frame_done = 1'b0;
    logic [4:0]  rx_end_bytes = 5'd1;
    logic        tx_close_sent = 1'b0;
    logic        tx_abort_sent = 1'b0;
    logic        tx_underrun = 1'b0;
    logic        cts_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    hdlc_stat_reg dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .quad_mode(quad_mode), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_free(tx_free), .rx_fill(rx_fill), .rx_last_mark(rx_last_mark),
        .rx_frame_done(rx_frame_done), .rx_end_bytes(rx_end_bytes),
        .tx_close_sent(tx_close_sent), .tx_abort_sent(tx_abort_sent),
        .tx_underrun(tx_underrun), .cts_n(cts_n)
    );

    // expected-value functions written from the requirements
    function automatic bit f_txav(int free, bit q, bit dma);
        if (dma) return 1'b0;
        return q ? (free >= 4) : (free != 0);
    endfunction

    function automatic bit f_rxav(int fill, bit q, bit last, bit dma);
        if (dma) return 1'b0;
        return q ? ((fill >= 4) || (fill != 0 && last)) : (fill != 0);
    endfunction

    function automatic logic [3:0] f_rem(int bytes, bit q);
        int v;
        v = (bytes == 0) ? 0 : bytes - 1;
        return q ? 4'(v) : 4'(v % 4);
    endfunction

    // cycle model of the status word
    logic [3:0]  m_rem;
    logic        m_done, m_txav, m_lvl, m_chg, m_ur, m_rxav;
    logic [31:0] m_ien;
    logic        m_s1, m_s2, m_prev;

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] clr;
        if (!rst_n) begin
            m_rem <= '0; m_done <= 0; m_txav <= 0; m_lvl <= 0; m_chg <= 0;
            m_ur <= 0; m_rxav <= 0; m_ien <= '0;
            m_s1 <= 1; m_s2 <= 1; m_prev <= 1;
        end else begin
            clr = (cpu_wr && !cpu_addr) ? cpu_wdata : 32'h0;
            m_s1 <= cts_n; m_s2 <= m_s1; m_prev <= m_s2;
            m_lvl  <= ~m_s2;
            m_chg  <= (m_chg & ~clr[8]) | (m_s2 ^ m_prev);
            m_done <= (m_done & ~clr[5]) | ((tx_close_sent | tx_abort_sent) & (tx_free == 4'd8));
            m_ur   <= (m_ur & ~clr[9]) | tx_underrun;
            m_txav <= f_txav(int'(tx_free), quad_mode, tx_dma_en);
            m_rxav <= f_rxav(int'(rx_fill), quad_mode, rx_last_mark, rx_dma_en);
            if (rx_frame_done) m_rem <= f_rem(int'(rx_end_bytes), quad_mode);
            if (cpu_wr && cpu_addr) m_ien <= cpu_wdata & 32'h0000_0760;
        end
    end

    function automatic logic [31:0] exp_stat();
        logic [31:0] s;
        s = '0;
        s[3:0] = m_rem; s[5] = m_done; s[6] = m_txav; s[7] = m_lvl;
        s[8] = m_chg; s[9] = m_ur; s[10] = m_rxav;
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (!cpu_addr) begin
            chk("R2 remaining bytes", 32'(cpu_rdata[3:0]), 32'(m_rem));
            chk("R3 frame complete", 32'(cpu_rdata[5]), 32'(m_done));
            chk("R4 tx available", 32'(cpu_rdata[6]), 32'(m_txav));
            chk("R5 cts level", 32'(cpu_rdata[7]), 32'(m_lvl));
            chk("R6 cts change", 32'(cpu_rdata[8]), 32'(m_chg));
            chk("R7 underrun", 32'(cpu_rdata[9]), 32'(m_ur));
            chk("R8 rx available", 32'(cpu_rdata[10]), 32'(m_rxav));
            chk("R11 reserved zero", {cpu_rdata[31:11], cpu_rdata[4]}, 32'h0);
        end else begin
            chk("R11 enable readback", cpu_rdata, m_ien);
        end
        chk("R10 irq", 32'(irq), 32'(|(exp_stat() & m_ien & 32'h0000_0760)));
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_strobes();
        cpu_wr = 0; rx_frame_done = 0; tx_close_sent = 0;
        tx_abort_sent = 0; tx_underrun = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1d1c_5a77));
        // R1: reset state
        repeat (3) @(negedge clk);
        cpu_addr = 0; #1;
        chk("R1 reset status", cpu_rdata, 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        cpu_addr = 1; #1;
        chk("R1 reset enable", cpu_rdata, 32'h0);
        cpu_addr = 0;
        rst_n = 1;
        step();
        chk("R1 after release", cpu_rdata, 32'h0);

        // enable all interrupt sources
        cpu_wr = 1; cpu_addr = 1; cpu_wdata = 32'hFFFF_FFFF;
        step();
        clear_strobes(); cpu_addr = 0;

        // R4 / R8 threshold sweeps in both modes, with and without last marker
        for (int q = 0; q < 2; q++) begin
            for (int lm = 0; lm < 2; lm++) begin
                for (int c = 0; c <= 8; c++) begin
                    quad_mode = q[0]; rx_last_mark = lm[0];
                    tx_free = 4'(c); rx_fill = 4'(c);
                    step();
                    step();
                end
            end
        end

        // R2: every byte count in both modes
        for (int q = 0; q < 2; q++) begin
            for (int b = 0; b <= 16; b++) begin
                quad_mode = q[0]; rx_end_bytes = 5'(b); rx_frame_done = 1;
                step();
                rx_frame_done = 0; rx_end_bytes = 5'd9;
                step();
            end
        end

        // R3: close with a non-empty FIFO does not set; with empty FIFO sets
        tx_free = 4'd7; tx_close_sent = 1;
        step();
        chk("R3 no set when not empty", 32'(cpu_rdata[5]), 32'h0);
        tx_close_sent = 0; tx_free = 4'd8; tx_abort_sent = 1;
        step();
        chk("R3 abort with empty fifo", 32'(cpu_rdata[5]), 32'h1);

        // R9: set and clear in the same cycle, bits 5 and 9
        tx_abort_sent = 1; tx_underrun = 1;
        cpu_wr = 1; cpu_addr = 0; cpu_wdata = 32'h0000_0220;
        step();
        chk("R9 underrun set beats clear", 32'(cpu_rdata[9]), 32'h1);
        chk("R9 frame done set beats clear", 32'(cpu_rdata[5]), 32'h1);
        clear_strobes();

        // R5 / R6: CTS edges
        cts_n = 0;
        repeat (4) step();
        chk("R5 cts low reads one", 32'(cpu_rdata[7]), 32'h1);
        chk("R6 falling edge seen", 32'(cpu_rdata[8]), 32'h1);
        cpu_wr = 1; cpu_wdata = 32'h0000_0100;
        step();
        clear_strobes();
        step();
        chk("R6 cleared by write", 32'(cpu_rdata[8]), 32'h0);
        cts_n = 1;
        repeat (4) step();
        chk("R6 rising edge seen", 32'(cpu_rdata[8]), 32'h1);
        chk("R5 cts high reads zero", 32'(cpu_rdata[7]), 32'h0);

        // R11: writing zeros keeps sticky bits
        cpu_wr = 1; cpu_wdata = 32'h0; step(); clear_strobes();
        chk("R11 zero write keeps sticky", 32'(cpu_rdata[8]), 32'h1);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            clear_strobes();
            cpu_addr = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) begin
                cpu_wr = 1; cpu_wdata = $urandom();
            end
            if ($urandom_range(0, 3) == 0) tx_free = 4'($urandom_range(0, 8));
            if ($urandom_range(0, 3) == 0) rx_fill = 4'($urandom_range(0, 8));
            if ($urandom_range(0, 15) == 0) tx_dma_en = ~tx_dma_en;
            if ($urandom_range(0, 15) == 0) rx_dma_en = ~rx_dma_en;
            if ($urandom_range(0, 31) == 0) quad_mode = ~quad_mode;
            if ($urandom_range(0, 9) == 0) cts_n = ~cts_n;
            rx_last_mark = 1'($urandom_range(0, 1));
            tx_close_sent = ($urandom_range(0, 5) == 0);
            tx_abort_sent = ($urandom_range(0, 11) == 0);
            tx_underrun = ($urandom_range(0, 9) == 0);
            rx_frame_done = ($urandom_range(0, 5) == 0);
            rx_end_bytes = 5'($urandom_range(0, 16));
            step();
        end
        clear_strobes();
        step();
        finish_run();
    end

endmodule